// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers up to 32 interrupt sources and drives two request lines toward a processor core: a normal request and a fast request. Every source has its own enable bit for each request type and a 3-bit priority. For each type the block forms the status vector, which is the raw sources ANDed with that type's enables. With nesting off, the request line is the OR of that status. With nesting on, the block selects the best pending source and keeps a stack of the priorities currently in service, up to eight levels deep per type.

Software works the block through a small register port. Reading a vector register returns the winning source and takes it into service, which pushes its priority onto the stack. An end-of-service write pops one level. Four external pins replace sources 16 to 19. Each pin can be set to active-high level, active-low level, rising-edge or falling-edge triggering. An edge is held in a latch until software clears it. The fast type always wins over the normal type.

Top module: `prio_intc`

## Requirements
- R1: Reading the normal-status register (address 0x02) or the fast-status register (0x03) returns the effective sources ANDed with the enable register of that type (normal 0x00, fast 0x01). The value reflects the state in the cycle of the read.
- R2: When nesting is off for a type, its request is the OR of its status, registered one cycle later. A vector read for that type returns 0.
- R3: The fast request line `fiq_o` has no mask from the normal type. `irq_o` is held low whenever the fast type is requesting or the fast stack is not empty.
- R4: In the nesting-control register (0x04), bit 0 turns on nesting for the normal type and bit 1 for the fast type. While a bit is 0, that type's stack is emptied.
- R5: With nesting on, the candidate is the status source with the highest priority. On equal priority, the lower source number wins. A vector read (normal 0x07, fast 0x08) returns bit 8 = 1 and the source number in bits 4:0 when a candidate may enter service, and 0 otherwise.
- R6: A vector read that returns a valid candidate pushes its priority. The level register (normal 0x09, fast 0x0A) returns the depth in bits 7:4, a non-empty flag in bit 3 and the top priority in bits 2:0.
- R7: With a non-empty stack, a candidate raises the request or enters service only if its priority is strictly above the top priority. The stack holds at most 8 entries.
- R8: A write to the end-of-service register (normal 0x0B, fast 0x0C) pops one level. On an empty stack the write has no effect.
- R9: External pin k replaces source 16+k. The mode field sits in bits 2k+1:2k of register 0x05: 0 = active-high level, 1 = rising edge, 2 = falling edge, 3 = active-low level.
- R10: An edge-mode pin latches the edge until a write to register 0x06 has a 1 in bit k. Bits 31:4 of that write are ignored. An edge and a clear in the same cycle leave the latch set.
- R11: Priority registers 0x10 to 0x13 hold eight sources each. Source 8g+i is at address 0x10+g, bits 4i+2:4i. The other bits read back as 0.
- R12: After reset, all registers, stacks, latches, both request lines and the read data are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Raw interrupt sources, active high |
| ext_i | input | 4 | External interrupt pins |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_re` |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
Two events can collide on a pin latch: an edge arriving on an external pin and a software clear of that same pin. The bench forces both into one clock, raising the pin on the same edge that carries the clear write, and then expects the latch to stay set. A second collision comes from the random phase, which overlaps vector reads, end-of-service writes and nesting toggles with source changes. There a behavioural model holding the stacks as queues judges every cycle's request lines and read data.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
  typedef enum logic [1:0] {
    EXT_LVL_HI = 2'd0,
    EXT_RISE   = 2'd1,
    EXT_FALL   = 2'd2,
    EXT_LVL_LO = 2'd3
  } ext_mode_e;

  localparam logic [4:0] A_EN_IRQ  = 5'h00;
  localparam logic [4:0] A_EN_FIQ  = 5'h01;
  localparam logic [4:0] A_ST_IRQ  = 5'h02;
  localparam logic [4:0] A_ST_FIQ  = 5'h03;
  localparam logic [4:0] A_NEST    = 5'h04;
  localparam logic [4:0] A_EXTMODE = 5'h05;
  localparam logic [4:0] A_EXTCLR  = 5'h06;
  localparam logic [4:0] A_VEC_IRQ = 5'h07;
  localparam logic [4:0] A_LVL_IRQ = 5'h09;
  localparam logic [4:0] A_EOI_IRQ = 5'h0B;
  localparam logic [4:0] A_PRIO0   = 5'h10;
endpackage

// File: rtl/prio_intc_ext.sv
module prio_intc_ext
  import prio_intc_pkg::*;
#(
  parameter int NEXT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NEXT-1:0]   pin_i,
  input  logic [2*NEXT-1:0] mode_i,
  input  logic [NEXT-1:0]   clr_i,
  output logic [NEXT-1:0]   cond_o
);
  logic [NEXT-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= pin_i;
  end

  for (genvar k = 0; k < NEXT; k++) begin : g_pin
    ext_mode_e m;
    logic      lat_q;
    logic      set_c;

    assign m     = ext_mode_e'(mode_i[2*k +: 2]);
    assign set_c = ((m == EXT_RISE) &&  pin_i[k] && !prev_q[k]) ||
                   ((m == EXT_FALL) && !pin_i[k] &&  prev_q[k]);

    always_ff @(posedge clk) begin
      if (rst)           lat_q <= 1'b0;
      else if (set_c)    lat_q <= 1'b1;   // an edge wins over a clear
      else if (clr_i[k]) lat_q <= 1'b0;
    end

    always_comb begin
      case (m)
        EXT_LVL_HI: cond_o[k] = pin_i[k];
        EXT_LVL_LO: cond_o[k] = !pin_i[k];
        default:    cond_o[k] = lat_q;
      endcase
    end

    // R10: a latched edge is released only by a clear
    a_r10_edge_hold: assert property (@(posedge clk) disable iff (rst)
      (lat_q && !clr_i[k]) |=> lat_q);
  end
endmodule

// File: rtl/prio_intc_nest.sv
module prio_intc_nest #(
  parameter int NSRC = 32,
  parameter int PW   = 3,
  parameter int NEST = 8,
  localparam int IDW = $clog2(NSRC),
  localparam int DW  = $clog2(NEST + 1),
  localparam int SW  = (NEST > 1) ? $clog2(NEST) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NSRC-1:0]    status_i,
  input  logic [NSRC*PW-1:0] prio_i,
  input  logic               nest_en_i,
  input  logic               take_i,
  input  logic               done_i,
  output logic               req_o,
  output logic               pend_o,
  output logic [IDW-1:0]     best_id_o,
  output logic [DW-1:0]      depth_o,
  output logic [PW-1:0]      top_prio_o
);
  logic [PW-1:0]  stk_p [NEST];
  logic [DW-1:0]  depth_q;
  logic           best_v;
  logic [PW-1:0]  best_p;
  logic [IDW-1:0] best_id;
  logic [PW-1:0]  top_p;
  logic           push, pop;

  // highest priority wins; strict compare keeps the lowest index on ties
  always_comb begin
    best_v  = 1'b0;
    best_p  = '0;
    best_id = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (status_i[i] && (!best_v || prio_i[i*PW +: PW] > best_p)) begin
        best_v  = 1'b1;
        best_p  = prio_i[i*PW +: PW];
        best_id = IDW'(i);
      end
    end
  end

  assign top_p  = (depth_q == '0) ? '0 : stk_p[SW'(depth_q - 1'b1)];
  assign pend_o = nest_en_i && best_v && (depth_q != DW'(NEST)) &&
                  ((depth_q == '0) || (best_p > top_p));
  assign req_o  = nest_en_i ? pend_o : (status_i != '0);
  assign push   = take_i && pend_o;
  assign pop    = done_i && nest_en_i && (depth_q != '0);

  always_ff @(posedge clk) begin
    if (push) stk_p[depth_q[SW-1:0]] <= best_p;
  end

  always_ff @(posedge clk) begin
    if (rst)            depth_q <= '0;
    else if (!nest_en_i) depth_q <= '0;
    else if (push)      depth_q <= depth_q + 1'b1;
    else if (pop)       depth_q <= depth_q - 1'b1;
  end

  assign best_id_o  = best_id;
  assign depth_o    = depth_q;
  assign top_prio_o = top_p;

  // R4: with nesting off the stack is empty one cycle later
  a_r4_flat_empty: assert property (@(posedge clk) disable iff (rst)
    !nest_en_i |=> (depth_q == '0));
  // R7: each stacked level sits strictly above the one beneath
  a_r7_strict_stack: assert property (@(posedge clk) disable iff (rst)
    (push && depth_q != '0) |=> (top_p > $past(top_p)));
  // R7: depth never exceeds the nesting limit
  a_r7_depth_bound: assert property (@(posedge clk) disable iff (rst)
    depth_q <= DW'(NEST));
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter int NSRC     = 32,
  parameter int PW       = 3,
  parameter int NEST     = 8,
  parameter int NEXT     = 4,
  parameter int EXT_BASE = 16,
  localparam int AW   = 5,
  localparam int DWD  = 32,
  localparam int NGRP = NSRC / 8,
  localparam int IDW  = $clog2(NSRC),
  localparam int DW   = $clog2(NEST + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_i,
  input  logic [NEXT-1:0] ext_i,
  input  logic            reg_we,
  input  logic            reg_re,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DWD-1:0]  reg_wdata,
  output logic [DWD-1:0]  reg_rdata,
  output logic            irq_o,
  output logic            fiq_o
);
  logic [NSRC-1:0]    en_q [2];
  logic [1:0]         nest_q;
  logic [2*NEXT-1:0]  mode_q;
  logic [NSRC*PW-1:0] prio_q;
  logic [NEXT-1:0]    ext_c, clr_c;
  logic [NSRC-1:0]    raw_c;
  logic [NSRC-1:0]    stat [2];
  logic               req_c [2];
  logic               pend_c [2];
  logic [IDW-1:0]     bid [2];
  logic [DW-1:0]      dep [2];
  logic [PW-1:0]      topp [2];
  logic [DWD-1:0]     rd_c;
  logic               irq_q, fiq_q;

  assign clr_c = (reg_we && reg_addr == A_EXTCLR) ? reg_wdata[NEXT-1:0] : '0;

  prio_intc_ext #(.NEXT(NEXT)) u_ext (
    .clk(clk), .rst(rst), .pin_i(ext_i), .mode_i(mode_q),
    .clr_i(clr_c), .cond_o(ext_c)
  );

  always_comb begin
    raw_c = src_i;
    raw_c[EXT_BASE +: NEXT] = ext_c;
  end

  // index 0: normal type, index 1: fast type
  for (genvar t = 0; t < 2; t++) begin : g_type
    assign stat[t] = raw_c & en_q[t];
    prio_intc_nest #(.NSRC(NSRC), .PW(PW), .NEST(NEST)) u_nest (
      .clk(clk), .rst(rst), .status_i(stat[t]), .prio_i(prio_q),
      .nest_en_i(nest_q[t]),
      .take_i(reg_re && reg_addr == A_VEC_IRQ + 5'(t)),
      .done_i(reg_we && reg_addr == A_EOI_IRQ + 5'(t)),
      .req_o(req_c[t]), .pend_o(pend_c[t]), .best_id_o(bid[t]),
      .depth_o(dep[t]), .top_prio_o(topp[t])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q[0] <= '0;
      en_q[1] <= '0;
      nest_q  <= '0;
      mode_q  <= '0;
      prio_q  <= '0;
    end else if (reg_we) begin
      if (reg_addr == A_EN_IRQ)       en_q[0] <= reg_wdata[NSRC-1:0];
      if (reg_addr == A_EN_IRQ + 5'd1) en_q[1] <= reg_wdata[NSRC-1:0];
      if (reg_addr == A_NEST)         nest_q  <= reg_wdata[1:0];
      if (reg_addr == A_EXTMODE)      mode_q  <= reg_wdata[2*NEXT-1:0];
      for (int g = 0; g < NGRP; g++)
        if (reg_addr == A_PRIO0 + 5'(g))
          for (int i = 0; i < 8; i++)
            prio_q[(8*g+i)*PW +: PW] <= reg_wdata[4*i +: PW];
    end
  end

  always_comb begin
    rd_c = '0;
    case (reg_addr)
      A_EN_IRQ:         rd_c[NSRC-1:0]   = en_q[0];
      A_EN_IRQ + 5'd1:  rd_c[NSRC-1:0]   = en_q[1];
      A_ST_IRQ:         rd_c[NSRC-1:0]   = stat[0];
      A_ST_FIQ:         rd_c[NSRC-1:0]   = stat[1];
      A_NEST:           rd_c[1:0]        = nest_q;
      A_EXTMODE:        rd_c[2*NEXT-1:0] = mode_q;
      A_VEC_IRQ:        if (pend_c[0]) rd_c = 32'h100 | DWD'(bid[0]);
      A_VEC_IRQ + 5'd1: if (pend_c[1]) rd_c = 32'h100 | DWD'(bid[1]);
      A_LVL_IRQ:        rd_c = (DWD'(dep[0]) << 4) | (DWD'(dep[0] != '0) << 3) | DWD'(topp[0]);
      A_LVL_IRQ + 5'd1: rd_c = (DWD'(dep[1]) << 4) | (DWD'(dep[1] != '0) << 3) | DWD'(topp[1]);
      default:          rd_c = '0;
    endcase
    for (int g = 0; g < NGRP; g++)
      if (reg_addr == A_PRIO0 + 5'(g))
        for (int i = 0; i < 8; i++)
          rd_c[4*i +: PW] = prio_q[(8*g+i)*PW +: PW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq_q     <= 1'b0;
      fiq_q     <= 1'b0;
    end else begin
      reg_rdata <= reg_re ? rd_c : '0;
      fiq_q     <= req_c[1];
      irq_q     <= req_c[0] && !req_c[1] && (dep[1] == '0);
    end
  end

  assign irq_o = irq_q;
  assign fiq_o = fiq_q;

  // R3: fast work in service keeps the normal line quiet
  a_r3_fiq_first: assert property (@(posedge clk) disable iff (rst)
    (dep[1] != '0) |=> !irq_o);
  // R3: the two lines never assert together
  a_r3_exclusive: assert property (@(posedge clk) disable iff (rst)
    fiq_o |-> !irq_o);
  // R2: flat mode raises the normal line from any enabled source
  a_r2_flat_or: assert property (@(posedge clk) disable iff (rst)
    (!nest_q[0] && stat[0] != '0 && !req_c[1] && dep[1] == '0) |=> irq_o);
endmodule

// File: tb/prio_intc_bench.sv
`timescale 1ns/1ps
module prio_intc_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src = '0;
  logic [3:0]  ext = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, fiq;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prio_intc u_prio_intc (
    .clk(clk), .rst(rst), .src_i(src), .ext_i(ext), .reg_we(we), .reg_re(re),
    .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata), .irq_o(irq), .fiq_o(fiq)
  );

  // ---------------- behavioural reference model ----------------
  bit [31:0] m_en [2];
  bit [1:0]  m_nest;
  bit [7:0]  m_mode;
  int        m_pr [32];
  bit [3:0]  m_prev, m_lat;
  int        m_stk0 [$];
  int        m_stk1 [$];
  bit        e_irq, e_fiq;
  bit [31:0] e_rd;
  bit [31:0] mraw, mst [2];
  int        mbp [2], mbi [2], mdep [2], mtop [2];
  bit        mbv [2], mpend [2], mreq [2];
  int        mm;
  bit        mset;

  always @(posedge clk) begin
    if (rst) begin
      m_en[0] = 0; m_en[1] = 0; m_nest = 0; m_mode = 0; m_prev = 0; m_lat = 0;
      for (int i = 0; i < 32; i++) m_pr[i] = 0;
      m_stk0.delete(); m_stk1.delete();
      e_irq = 0; e_fiq = 0; e_rd = 0;
    end else begin
      mraw = src;
      for (int k = 0; k < 4; k++) begin
        mm = int'(m_mode[2*k +: 2]);
        mraw[16+k] = (mm == 0) ? ext[k] : (mm == 3) ? !ext[k] : m_lat[k];
      end
      mdep[0] = m_stk0.size(); mdep[1] = m_stk1.size();
      mtop[0] = mdep[0] ? m_stk0[mdep[0]-1] : 0;
      mtop[1] = mdep[1] ? m_stk1[mdep[1]-1] : 0;
      for (int t = 0; t < 2; t++) begin
        mst[t] = mraw & m_en[t];
        mbv[t] = 0; mbp[t] = 0; mbi[t] = 0;
        for (int i = 0; i < 32; i++)
          if (mst[t][i] && (!mbv[t] || m_pr[i] > mbp[t])) begin
            mbv[t] = 1; mbp[t] = m_pr[i]; mbi[t] = i;
          end
        mpend[t] = m_nest[t] && mbv[t] && mdep[t] < 8 && (mdep[t] == 0 || mbp[t] > mtop[t]);
        mreq[t]  = m_nest[t] ? mpend[t] : (mst[t] != 0);
      end
      e_fiq = mreq[1];
      e_irq = mreq[0] && !mreq[1] && mdep[1] == 0;
      e_rd = 0;
      if (re) begin
        case (addr)
          5'h00: e_rd = m_en[0];
          5'h01: e_rd = m_en[1];
          5'h02: e_rd = mst[0];
          5'h03: e_rd = mst[1];
          5'h04: e_rd = 32'(m_nest);
          5'h05: e_rd = 32'(m_mode);
          5'h07: e_rd = mpend[0] ? (32'h100 | 32'(mbi[0])) : 0;
          5'h08: e_rd = mpend[1] ? (32'h100 | 32'(mbi[1])) : 0;
          5'h09: e_rd = 32'((mdep[0] << 4) | ((mdep[0] != 0) << 3) | mtop[0]);
          5'h0A: e_rd = 32'((mdep[1] << 4) | ((mdep[1] != 0) << 3) | mtop[1]);
          default: ;
        endcase
        for (int g = 0; g < 4; g++)
          if (int'(addr) == 16 + g)
            for (int i = 0; i < 8; i++) e_rd = e_rd | 32'(m_pr[8*g+i] << (4*i));
      end
      // stacks
      if (!m_nest[0]) m_stk0.delete();
      else if (re && addr == 5'h07 && mpend[0]) m_stk0.push_back(mbp[0]);
      else if (we && addr == 5'h0B && mdep[0] > 0) void'(m_stk0.pop_back());
      if (!m_nest[1]) m_stk1.delete();
      else if (re && addr == 5'h08 && mpend[1]) m_stk1.push_back(mbp[1]);
      else if (we && addr == 5'h0C && mdep[1] > 0) void'(m_stk1.pop_back());
      // latches
      for (int k = 0; k < 4; k++) begin
        mm = int'(m_mode[2*k +: 2]);
        mset = (mm == 1 && ext[k] && !m_prev[k]) || (mm == 2 && !ext[k] && m_prev[k]);
        if (mset) m_lat[k] = 1;
        else if (we && addr == 5'h06 && wdata[k]) m_lat[k] = 0;
      end
      m_prev = ext;
      if (we) begin
        if (addr == 5'h00) m_en[0] = wdata;
        if (addr == 5'h01) m_en[1] = wdata;
        if (addr == 5'h04) m_nest = wdata[1:0];
        if (addr == 5'h05) m_mode = wdata[7:0];
        for (int g = 0; g < 4; g++)
          if (int'(addr) == 16 + g)
            for (int i = 0; i < 8; i++) m_pr[8*g+i] = int'(wdata[4*i +: 3]);
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks += 3;
      if (irq !== e_irq) begin fails++; $display("FAIL R2 model irq_o act=%0d exp=%0d", irq, e_irq); end
      if (fiq !== e_fiq) begin fails++; $display("FAIL R3 model fiq_o act=%0d exp=%0d", fiq, e_fiq); end
      if (rdata !== e_rd) begin fails++; $display("FAIL R5 model rdata act=%h exp=%h", rdata, e_rd); end
    end
  end

  // ---------------- directed helpers ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); re = 1'b1; addr = a;
    @(negedge clk); re = 1'b0; d = rdata;
  endtask

  logic [31:0] v;

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R12: reset state
    rd(5'h00, v); chk("R12 enable after reset", v, 32'h0);
    chk("R12 irq_o after reset", 32'(irq), 32'h0);
    chk("R12 fiq_o after reset", 32'(fiq), 32'h0);
    // R1: status
    wr(5'h00, 32'h0000_00F0);
    src = 32'h0000_0030;
    rd(5'h02, v); chk("R1 normal status", v, 32'h30);
    rd(5'h03, v); chk("R1 fast status", v, 32'h0);
    // R2: flat OR line, empty vector
    chk("R2 flat irq", 32'(irq), 32'h1);
    rd(5'h07, v); chk("R2 vector in flat mode", v, 32'h0);
    // R3: fast over normal
    wr(5'h01, 32'h0000_0020);
    @(negedge clk);
    chk("R3 fiq high", 32'(fiq), 32'h1);
    chk("R3 irq masked", 32'(irq), 32'h0);
    wr(5'h01, 32'h0);
    // R11, R5, R6: priorities and selection
    wr(5'h10, 32'h1552_0000);
    rd(5'h10, v); chk("R11 priority readback", v, 32'h1552_0000);
    src = 32'h0000_0070;
    wr(5'h04, 32'h1);
    rd(5'h07, v); chk("R5 tie picks lower source", v, 32'h105);
    rd(5'h09, v); chk("R6 level after push", v, 32'h1D);
    @(negedge clk);
    chk("R7 equal priority waits", 32'(irq), 32'h0);
    // R7: strictly higher preempts
    wr(5'h11, 32'h7);
    wr(5'h00, 32'h0000_01F0);
    src = 32'h0000_0170;
    repeat (2) @(negedge clk);
    chk("R7 higher priority requests", 32'(irq), 32'h1);
    rd(5'h07, v); chk("R7 preempting vector", v, 32'h108);
    rd(5'h09, v); chk("R7 level depth two", v, 32'h2F);
    // R8: end of service
    wr(5'h0B, 32'h0); rd(5'h09, v); chk("R8 pop one level", v, 32'h1D);
    wr(5'h0B, 32'h0); rd(5'h09, v); chk("R8 pop to empty", v, 32'h0);
    wr(5'h0B, 32'h0); rd(5'h09, v); chk("R8 pop on empty ignored", v, 32'h0);
    // R4: clearing the nesting bit empties the stack
    rd(5'h07, v); chk("R4 vector before disable", v, 32'h108);
    wr(5'h04, 32'h0); wr(5'h04, 32'h1);
    rd(5'h09, v); chk("R4 stack emptied", v, 32'h0);
    wr(5'h04, 32'h0); src = '0; wr(5'h00, 32'h000F_0000);
    // R9: external modes (pin0 rise, pin1 low level, pin2 rise, pin3 fall)
    wr(5'h05, 32'h9D);
    rd(5'h02, v); chk("R9 low level pin active", v, 32'h0002_0000);
    @(negedge clk); ext[0] = 1'b1;
    rd(5'h02, v); chk("R9 rising edge seen", v, 32'h0003_0000);
    @(negedge clk); ext[0] = 1'b0;
    rd(5'h02, v); chk("R9 rising edge latched", v, 32'h0003_0000);
    @(negedge clk); ext[3] = 1'b1;
    @(negedge clk); ext[3] = 1'b0;
    rd(5'h02, v); chk("R9 falling edge latched", v, 32'h000B_0000);
    // R10: clear behaviour
    wr(5'h06, 32'hFFFF_FFF0);
    rd(5'h02, v); chk("R10 reserved clear bits ignored", v, 32'h000B_0000);
    wr(5'h06, 32'h1);
    rd(5'h02, v); chk("R10 clear releases latch", v, 32'h000A_0000);
    @(negedge clk); ext[2] = 1'b1; we = 1'b1; addr = 5'h06; wdata = 32'h4;
    @(negedge clk); we = 1'b0;
    rd(5'h02, v); chk("R10 edge wins over same-cycle clear", v, 32'h000E_0000);
    wr(5'h06, 32'hC);
    rd(5'h02, v); chk("R10 clear two latches", v, 32'h0002_0000);
    // random phase judged by the model
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      src   = $urandom & $urandom;
      if (($urandom % 8) == 0) ext = 4'($urandom);
      we    = (($urandom % 5) == 0);
      re    = !we && (($urandom % 2) == 0);
      addr  = (($urandom % 4) == 0) ? 5'(16 + $urandom % 4) : 5'($urandom % 13);
      wdata = $urandom;
      if (we && addr == 5'h04) wdata = (($urandom % 4) == 0) ? 32'h0 : 32'h3;
    end
    @(negedge clk); we = 1'b0; re = 1'b0;
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL R12 watchdog expired act=running exp=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule